// File: doc/BRIEF.md
# Direct-Page Load Address Sequencer

This block fetches and executes a single kind of instruction: a load of one byte into an accumulator. The load comes in two encodings. The short encoding carries a one-byte offset into a 256-byte window called the direct page. The long encoding carries a complete 16-bit address. The block keeps a program counter and presents a 16-bit address with a read strobe to a byte memory. The memory returns the addressed byte in the same cycle, and the block registers it at the next clock edge. The block decodes the opcode, collects the operand bytes, forms the effective address, reads the data byte and writes it into the accumulator.

A base register sets where the direct-page window starts. It is written through a dedicated port and clears on reset, so after reset the short encoding reaches physical addresses 0x0000 to 0x00FF. Because the short encoding has one operand byte fewer, it needs one bus cycle less than the long encoding. A `run` input lets the block start the next instruction. While `run` is low between instructions, the block stays idle and does not use the bus.

Top module: `dp_load_seq`

## Requirements
- R1: After reset, `acc` is 0x00, `pc` is 0x0000, `done` is 0, `mem_rd` is 0 while `run` is low, and the page base is 0x0000.
- R2: Opcode 0xA5 is the short load. Its operand byte is an offset. It takes three cycles: opcode, offset, data. `done` is high in the third cycle, that cycle's `mem_addr` is the base plus the zero-extended offset, and after that cycle `acc` holds the byte at that address.
- R3: Opcode 0xAD is the long load. It takes four cycles: opcode, address low byte, address high byte, data. `done` is high in the fourth cycle, `mem_addr` in that cycle equals the assembled address, and `acc` then holds that byte.
- R4: With the base at zero, a short load of offset X and a long load of address 0x00XX put the same byte into `acc`.
- R5: `pc` increases by one for every opcode or operand byte fetched: +2 for a short load and +3 for a long load. Any other opcode takes one cycle, advances `pc` by one, leaves `acc` unchanged and raises no `done`.
- R6: A write on the base port takes effect from the following cycle. A short-load address formed in the same cycle as a base write uses the old base.
- R7: The short-form address is (base + offset) modulo 2^16, so it wraps past 0xFFFF.
- R8: While the sequencer waits for an opcode and `run` is low, `mem_rd` is 0 and `pc` holds its value.
- R9: `done` is high for exactly one cycle per load, and `mem_rd` is high in every cycle of an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Allows the next opcode fetch |
| dp_we | input | 1 | Base register write strobe |
| dp_wdata | input | 16 | New direct-page base |
| mem_rdata | input | 8 | Byte returned for `mem_addr` in the same cycle |
| mem_addr | output | 16 | Bus address |
| mem_rd | output | 1 | Read strobe |
| acc | output | 8 | Accumulator |
| pc | output | 16 | Program counter |
| done | output | 1 | High in the cycle in which the accumulator is written |

## Verification
A base register write and the formation of the short-form address can fall in the same clock edge. The bench provokes this by raising `dp_we` exactly in the offset cycle of a short load. It then judges the result in two steps: that load must read through the old base, and the next short load must read through the new one. Random programs that mix both encodings, unknown opcodes, random bases and wrap-around offsets are checked against a bench model of cycle count, `pc`, data-cycle address and `acc`.

// File: rtl/dpl_pkg.sv
package dpl_pkg;
    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_ARG_LO = 2'd1,
        ST_ARG_HI = 2'd2,
        ST_LOAD   = 2'd3
    } seq_state_e;
endpackage

// File: rtl/dpl_decode.sv
module dpl_decode #(
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  OP_SHORT = 8'hA5,
    parameter logic [7:0]  OP_LONG  = 8'hAD
) (
    input  logic [DATA_W-1:0] opcode,
    output logic              is_short,
    output logic              is_long
);
    always_comb begin
        is_short = (opcode == DATA_W'(OP_SHORT));
        is_long  = (opcode == DATA_W'(OP_LONG));
    end
endmodule

// File: rtl/dpl_ea_form.sv
module dpl_ea_form #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter bit RELOCATE = 1'b1
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [DATA_W-1:0] offset,
    output logic [ADDR_W-1:0] ea
);
    localparam int PAD_W = ADDR_W - DATA_W;

    generate
        if (RELOCATE) begin : g_reloc
            always_comb ea = base + {{PAD_W{1'b0}}, offset};
        end else begin : g_fixed
            logic unused_base;
            always_comb begin
                unused_base = ^base;
                ea = {{PAD_W{1'b0}}, offset};
            end
        end
    endgenerate
endmodule

// File: rtl/dp_load_seq.sv
module dp_load_seq #(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 8,
    parameter logic [15:0] RESET_PC = 16'h0000,
    parameter logic [7:0]  OP_SHORT = 8'hA5,
    parameter logic [7:0]  OP_LONG  = 8'hAD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              dp_we,
    input  logic [ADDR_W-1:0] dp_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic [DATA_W-1:0] acc,
    output logic [ADDR_W-1:0] pc,
    output logic              done
);
    import dpl_pkg::*;

    localparam int HI_W = ADDR_W - DATA_W;

    typedef struct packed {
        seq_state_e        state;
        logic              long_form;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] ea;
        logic [ADDR_W-1:0] base;
        logic [DATA_W-1:0] acc;
    } seq_t;

    seq_t s_d, s_q;
    logic is_short, is_long;
    logic [ADDR_W-1:0] short_ea;

    dpl_decode #(.DATA_W(DATA_W), .OP_SHORT(OP_SHORT), .OP_LONG(OP_LONG)) u_dec (
        .opcode   (mem_rdata),
        .is_short (is_short),
        .is_long  (is_long)
    );

    dpl_ea_form #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RELOCATE(1'b1)) u_ea (
        .base   (s_q.base),
        .offset (mem_rdata),
        .ea     (short_ea)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.state)
            ST_FETCH: begin
                if (run) begin
                    s_d.pc = s_q.pc + 1'b1;
                    if (is_short) begin
                        s_d.state     = ST_ARG_LO;
                        s_d.long_form = 1'b0;
                    end else if (is_long) begin
                        s_d.state     = ST_ARG_LO;
                        s_d.long_form = 1'b1;
                    end
                end
            end
            ST_ARG_LO: begin
                s_d.pc = s_q.pc + 1'b1;
                if (s_q.long_form) begin
                    s_d.ea[DATA_W-1:0] = mem_rdata;
                    s_d.state          = ST_ARG_HI;
                end else begin
                    s_d.ea    = short_ea;
                    s_d.state = ST_LOAD;
                end
            end
            ST_ARG_HI: begin
                s_d.pc                  = s_q.pc + 1'b1;
                s_d.ea[ADDR_W-1:DATA_W] = mem_rdata[HI_W-1:0];
                s_d.state               = ST_LOAD;
            end
            ST_LOAD: begin
                s_d.acc   = mem_rdata;
                s_d.state = ST_FETCH;
            end
            default: s_d.state = ST_FETCH;
        endcase
        if (dp_we) s_d.base = dp_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state     <= ST_FETCH;
            s_q.long_form <= 1'b0;
            s_q.pc        <= ADDR_W'(RESET_PC);
            s_q.ea        <= '0;
            s_q.base      <= '0;
            s_q.acc       <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        mem_addr = (s_q.state == ST_LOAD) ? s_q.ea : s_q.pc;
        mem_rd   = (s_q.state != ST_FETCH) || run;
        done     = (s_q.state == ST_LOAD);
        acc      = s_q.acc;
        pc       = s_q.pc;
    end

    // R2/R3: the accumulator takes the byte on the bus in the done cycle
    assert_done_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (acc == $past(mem_rdata)));

    // R5: acc changes only through a load
    assert_acc_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(acc));

    // R5: every byte fetched outside the data cycle moves pc by one
    assert_pc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !done) |=> (pc == $past(pc) + 1'b1));

    // R8: idle with run low holds pc
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd) |=> $stable(pc));

    // R9: done never lasts two cycles
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: base write lands on the next edge
    assert_base_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dp_we |=> (s_q.base == $past(dp_wdata)));
endmodule

// File: tb/dp_load_seq_tb.sv
`timescale 1ns/1ps
module dp_load_seq_tb;
    localparam logic [7:0] OPS = 8'hA5;
    localparam logic [7:0] OPL = 8'hAD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        dp_we = 1'b0;
    logic [15:0] dp_wdata = '0;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  acc;
    logic [15:0] pc;
    logic        done;

    logic [7:0]  mem_small [0:1023];

    int checks = 0;
    int errors = 0;

    logic [15:0] pc_m;
    logic [15:0] base_m;
    logic [7:0]  acc_m;

    always #4 clk = ~clk;

    function automatic logic [7:0] hash_byte(logic [15:0] a);
        return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'h5C;
    endfunction

    assign mem_rdata = (mem_addr < 16'd1024) ? mem_small[mem_addr[9:0]] : hash_byte(mem_addr);

    function automatic logic [7:0] model_rd(logic [15:0] a);
        return (a < 16'd1024) ? mem_small[a[9:0]] : hash_byte(a);
    endfunction

    dp_load_seq u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .dp_we(dp_we), .dp_wdata(dp_wdata),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .acc(acc), .pc(pc), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic write_base(input logic [15:0] v);
        @(negedge clk);
        dp_we = 1'b1; dp_wdata = v;
        @(negedge clk);
        dp_we = 1'b0;
        base_m = v;
    endtask

    // kind: 0 short, 1 long, 2 other opcode
    task automatic do_instr(input int kind, input logic [7:0] other_op,
                            input logic [15:0] opnd, input bit collide,
                            input logic [15:0] newbase);
        logic [15:0] ea;
        int len, dones, done_at;
        logic [15:0] done_addr;
        string rq;
        @(negedge clk);
        if (kind == 0) begin
            mem_small[pc_m[9:0]] = OPS;
            mem_small[pc_m[9:0] + 10'd1] = opnd[7:0];
            ea = base_m + {8'h00, opnd[7:0]};
            len = 3; rq = "R2";
        end else if (kind == 1) begin
            mem_small[pc_m[9:0]] = OPL;
            mem_small[pc_m[9:0] + 10'd1] = opnd[7:0];
            mem_small[pc_m[9:0] + 10'd2] = opnd[15:8];
            ea = opnd;
            len = 4; rq = "R3";
        end else begin
            mem_small[pc_m[9:0]] = other_op;
            ea = '0;
            len = 1; rq = "R5";
        end
        run = 1'b1;
        dones = 0; done_at = -1; done_addr = '0;
        for (int c = 1; c <= 5; c++) begin
            @(negedge clk);
            run = 1'b0;
            if (c == 1 && collide) begin dp_we = 1'b1; dp_wdata = newbase; end
            if (c == 2) dp_we = 1'b0;
            if (c < len) check(mem_rd == 1'b1, "R9", "mem_rd during instruction", 32'(mem_rd), 32'd1);
            if (done) begin dones++; done_at = c; done_addr = mem_addr; end
        end
        if (kind != 2) begin
            acc_m = model_rd(ea);
            check(dones == 1, "R9", "done count", 32'(dones), 32'd1);
            check(done_at == len - 1, rq, "done cycle", 32'(done_at), 32'(len - 1));
            check(done_addr == ea, rq, "data address", 32'(done_addr), 32'(ea));
        end else begin
            check(dones == 0, "R5", "no done on other opcode", 32'(dones), 32'd0);
        end
        pc_m = pc_m + 16'(len - (kind == 2 ? 0 : 1));
        check(acc == acc_m, rq, "accumulator", 32'(acc), 32'(acc_m));
        check(pc == pc_m, "R5", "pc advance", 32'(pc), 32'(pc_m));
        if (collide) base_m = newbase;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] a1, op;
        logic [15:0] b;
        int k;
        void'($urandom(32'h1D2E3F));
        for (int i = 0; i < 1024; i++) mem_small[i] = 8'(i * 37 + 11);
        pc_m = 16'h0000; base_m = 16'h0000; acc_m = 8'h00;
        #20;
        @(negedge clk);
        check(acc == 8'h00, "R1", "reset acc", 32'(acc), 32'h0);
        check(pc == 16'h0000, "R1", "reset pc", 32'(pc), 32'h0);
        check(done == 1'b0, "R1", "reset done", 32'(done), 32'h0);
        check(mem_rd == 1'b0, "R1", "reset mem_rd", 32'(mem_rd), 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(mem_rd == 1'b0, "R8", "idle no read", 32'(mem_rd), 32'h0);
        check(pc == 16'h0000, "R8", "idle pc hold", 32'(pc), 32'h0);

        // R1 and R4: base starts at zero; both forms reach the same byte
        mem_small[10'h012] = 8'h9B;
        do_instr(0, 8'h00, 16'h0012, 1'b0, 16'h0);
        a1 = acc;
        check(a1 == 8'h9B, "R4", "short form at zero base", 32'(a1), 32'h9B);
        do_instr(1, 8'h00, 16'h0012, 1'b0, 16'h0);
        check(acc == a1, "R4", "long form same byte", 32'(acc), 32'(a1));

        // R7: wrap past the top of the address space
        write_base(16'hFFC0);
        do_instr(0, 8'h00, 16'h0080, 1'b0, 16'h0);
        do_instr(0, 8'h00, 16'h00FF, 1'b0, 16'h0);

        // R6: base write in the offset cycle uses old base, then new base
        write_base(16'h4000);
        do_instr(0, 8'h00, 16'h0033, 1'b1, 16'h7100);
        do_instr(0, 8'h00, 16'h0033, 1'b0, 16'h0);

        // R5: unknown opcode
        do_instr(2, 8'h3C, 16'h0, 1'b0, 16'h0);

        // random mix
        for (int n = 0; n < 80; n++) begin
            k = int'($urandom % 8);
            if ($urandom % 4 == 0) write_base(16'($urandom));
            if (k < 4) begin
                do_instr(0, 8'h00, 16'($urandom), ($urandom % 6) == 0, 16'($urandom));
            end else if (k < 7) begin
                do_instr(1, 8'h00, 16'($urandom), 1'b0, 16'h0);
            end else begin
                op = 8'($urandom);
                if (op == OPS || op == OPL) op = 8'h00;
                do_instr(2, op, 16'h0, 1'b0, 16'h0);
            end
        end

        repeat (2) @(negedge clk);
        check(mem_rd == 1'b0, "R8", "final idle", 32'(mem_rd), 32'h0);
        check(pc == pc_m, "R8", "final pc hold", 32'(pc), 32'(pc_m));
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule